// File: doc/BRIEF.md
# Chained Transmit/Receive Command Queue

This block sits between a host and the transmit and receive engines of a token-passing network node. The host issues four kinds of command through one write port: enable transmit from a page, enable receive into a page, clear the transmit completion, and clear the receive completion. The block queues enable commands per direction and starts each engine with a one-cycle start pulse and a page number. Each engine reports the end of an operation with a done pulse; the transmitter also reports whether the packet was acknowledged.

Each completion is stored in a two-entry status queue. The head entry drives a completion flag in the status word, and a maskable interrupt. Only the matching clear command retires the head entry. The host can therefore service interrupts late without stalling back-to-back traffic. Chaining mode is selected by a configuration write. Without it, the block holds a single pending command per direction and a later enable replaces one that has not started.

Top module: `chain_cmd_ctrl`

## Requirements
- R1: After reset, chaining is off. The status word reads 0x11 (transmitter available in bit 0, receiver inhibited in bit 4). The interrupt, both overflow flags and both start pulses are low.
- R2: A configuration write with bit 6 = 1 turns chaining on. A write with bit 6 = 0 turns it off.
- R3: A transmit enable (op 0) clears the transmitter-available bit from the next cycle on. Starting from idle, tx_start is high for exactly one cycle, two cycles after the write, with tx_page equal to the written page. The transmit-acknowledged bit (bit 6) reads 0 while no completion is queued.
- R4: In chaining mode, a second enable in one direction is stored while the first runs. It starts, with its own page, in the cycle after the cycle in which the engine's done pulse is seen.
- R5: In chaining mode, an enable that arrives while two commands are outstanding in that direction is ignored. It sets that direction's sticky overflow flag, which only the matching clear command (op 2 for transmit, op 3 for receive) resets.
- R6: With chaining off, no overflow is ever raised. An enable that arrives while an earlier command is still waiting to start replaces that command's page.
- R7: A transmit done pulse sets the transmit completion flag (bit 7) in the next cycle, and bit 6 then shows the tx_ack value captured with it. A receive done pulse sets the receive completion flag (bit 5).
- R8: Completion status is double-buffered. A second completion does not change the head entry. After a clear, the second entry becomes the head in the next cycle.
- R9: A completion flag stays set until its clear command. A clear with no queued completion leaves the status unchanged.
- R10: irq is high exactly when (bit 7 AND irq_en_tx) OR (bit 5 AND irq_en_rx). It stays high after a clear while the second entry is valid and enabled.
- R11: Bits 0 and 4 show the live engine state: 1 while nothing is running or waiting in that direction. This holds independently of any completion flag.
- R12: Transmit and receive commands may be interleaved in any order. Each direction's queue, start pulses and flags are unaffected by the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 8 | Configuration data; bit 6 selects chaining |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | 0 tx enable, 1 rx enable, 2 tx clear, 3 rx clear |
| cmd_page | input | PAGE_W | Page number for enable commands |
| irq_en_tx | input | 1 | Interrupt enable for the transmit completion flag |
| irq_en_rx | input | 1 | Interrupt enable for the receive completion flag |
| tx_start | output | 1 | One-cycle start pulse to the transmit engine |
| tx_page | output | PAGE_W | Page for the transmit engine |
| tx_done | input | 1 | Transmit engine finished |
| tx_ack | input | 1 | Packet was acknowledged (valid with tx_done) |
| rx_start | output | 1 | One-cycle start pulse to the receive engine |
| rx_page | output | PAGE_W | Page for the receive engine |
| rx_done | input | 1 | Receive engine finished |
| status | output | 8 | Status word (bits 7,6,5,4,0 as in the requirements, others 0) |
| tx_ovf | output | 1 | Sticky transmit command overflow |
| rx_ovf | output | 1 | Sticky receive command overflow |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that an engine raises its done pulse only while it is running, that is, after its start pulse and at most once per start. They also assume that no more than two completions per direction are left uncleared. The stimulus models both engines by hand: done is pulsed only after the start pulse has been observed, and each pair of completions is cleared before new commands are issued. Page numbers, acknowledge values and interrupt-enable combinations are swept over their full small ranges, and expected status words are built from the bit positions in the requirements.

// File: rtl/ccq_pkg.sv
package ccq_pkg;
  typedef enum logic [1:0] {
    OP_TX_EN  = 2'd0,
    OP_RX_EN  = 2'd1,
    OP_TX_CLR = 2'd2,
    OP_RX_CLR = 2'd3
  } ccq_op_e;

  localparam int CFG_CHAIN_BIT = 6;
  localparam int ST_TX_FLAG    = 7;
  localparam int ST_TX_ACK     = 6;
  localparam int ST_RX_FLAG    = 5;
  localparam int ST_RX_INH     = 4;
  localparam int ST_TX_AVAIL   = 0;
  localparam int DIR_TX        = 0;
  localparam int DIR_RX        = 1;
endpackage

// File: rtl/ccq_fifo.sv
// Small shift-out queue: head at entry 0, optional overwrite of the head.
module ccq_fifo #(
  parameter int W     = 4,
  parameter int DEPTH = 2,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          replace,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] cnt
);
  logic [W-1:0]     mem [DEPTH];
  logic             shift;
  logic             push_ok;
  logic [CW-1:0]    tgt;
  logic [DEPTH-1:0] we;

  assign shift   = pop && (cnt != '0);
  assign push_ok = push && !replace && (shift || (cnt != CW'(DEPTH)));
  assign tgt     = shift ? cnt - CW'(1) : cnt;
  assign dout    = mem[0];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      we[i] = (replace && (i == 0)) || (push_ok && (tgt == CW'(i)));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we[i])
        mem[i] <= din;
      else if (shift && (i < DEPTH - 1))
        mem[i] <= mem[(i + 1) % DEPTH];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (replace)
      cnt <= CW'(1);
    else if (push_ok && !shift)
      cnt <= cnt + CW'(1);
    else if (!push_ok && shift)
      cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/ccq_chan.sv
// One direction: pending command queue, engine launch, completion queue.
module ccq_chan #(
  parameter int PAGE_W     = 4,
  parameter int CMD_DEPTH  = 2,
  parameter int DONE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chain_en,
  input  logic              en_cmd,
  input  logic              clr_cmd,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              eng_done,
  input  logic              eng_ack,
  output logic              eng_start,
  output logic [PAGE_W-1:0] eng_page,
  output logic              idle,
  output logic              flag,
  output logic              flag_ack,
  output logic              ovf
);
  localparam int CW = $clog2(CMD_DEPTH + 1);
  localparam int DW = $clog2(DONE_DEPTH + 1);

  logic              busy;
  logic [CW-1:0]     cmd_cnt;
  logic [PAGE_W-1:0] cmd_head;
  logic [CW:0]       outst;
  logic              full;
  logic              start_now;
  logic              cmd_push;
  logic              cmd_replace;
  logic [DW-1:0]     done_cnt;
  logic              done_head;

  assign start_now   = !busy && (cmd_cnt != '0);
  assign outst       = {1'b0, cmd_cnt} + {{CW{1'b0}}, busy};
  assign full        = chain_en && (outst >= (CW + 1)'(CMD_DEPTH));
  assign cmd_replace = en_cmd && !chain_en && (cmd_cnt != '0) && !start_now;
  assign cmd_push    = en_cmd && !full && !cmd_replace;

  ccq_fifo #(.W(PAGE_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk     (clk),
    .rst     (rst),
    .push    (cmd_push),
    .replace (cmd_replace),
    .pop     (start_now),
    .din     (page_in),
    .dout    (cmd_head),
    .cnt     (cmd_cnt)
  );

  ccq_fifo #(.W(1), .DEPTH(DONE_DEPTH)) u_doneq (
    .clk     (clk),
    .rst     (rst),
    .push    (eng_done && busy),
    .replace (1'b0),
    .pop     (clr_cmd),
    .din     (eng_ack),
    .dout    (done_head),
    .cnt     (done_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      eng_start <= 1'b0;
      eng_page  <= '0;
      ovf       <= 1'b0;
    end else begin
      eng_start <= start_now;
      if (start_now) begin
        busy     <= 1'b1;
        eng_page <= cmd_head;
      end else if (eng_done) begin
        busy <= 1'b0;
      end
      if (clr_cmd)
        ovf <= 1'b0;
      else if (en_cmd && full)
        ovf <= 1'b1;
    end
  end

  assign idle     = !busy && (cmd_cnt == '0);
  assign flag     = (done_cnt != '0);
  assign flag_ack = flag && done_head;
endmodule

// File: rtl/chain_cmd_ctrl.sv
module chain_cmd_ctrl
  import ccq_pkg::*;
#(
  parameter int PAGE_W     = 4,
  parameter int CMD_DEPTH  = 2,
  parameter int DONE_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_data,
  input  logic              cmd_wr,
  input  logic [1:0]        cmd_op,
  input  logic [PAGE_W-1:0] cmd_page,
  input  logic              irq_en_tx,
  input  logic              irq_en_rx,
  output logic              tx_start,
  output logic [PAGE_W-1:0] tx_page,
  input  logic              tx_done,
  input  logic              tx_ack,
  output logic              rx_start,
  output logic [PAGE_W-1:0] rx_page,
  input  logic              rx_done,
  output logic [7:0]        status,
  output logic              tx_ovf,
  output logic              rx_ovf,
  output logic              irq
);
  localparam int NDIR = 2;

  ccq_op_e           op;
  logic              chain_q;
  logic [NDIR-1:0]   en_v, clr_v, done_v, ack_v;
  logic [NDIR-1:0]   start_v, idle_v, flag_v, fack_v, ovf_v;
  logic [PAGE_W-1:0] page_v [NDIR];
  logic              rx_fack_unused;
  logic              cfg_bits_unused;

  assign op = ccq_op_e'(cmd_op);

  always_ff @(posedge clk) begin
    if (rst)
      chain_q <= 1'b0;
    else if (cfg_wr)
      chain_q <= cfg_data[CFG_CHAIN_BIT];
  end

  assign en_v[DIR_TX]  = cmd_wr && (op == OP_TX_EN);
  assign en_v[DIR_RX]  = cmd_wr && (op == OP_RX_EN);
  assign clr_v[DIR_TX] = cmd_wr && (op == OP_TX_CLR);
  assign clr_v[DIR_RX] = cmd_wr && (op == OP_RX_CLR);
  assign done_v        = {rx_done, tx_done};
  assign ack_v         = {1'b0, tx_ack};

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    ccq_chan #(
      .PAGE_W     (PAGE_W),
      .CMD_DEPTH  (CMD_DEPTH),
      .DONE_DEPTH (DONE_DEPTH)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .chain_en  (chain_q),
      .en_cmd    (en_v[d]),
      .clr_cmd   (clr_v[d]),
      .page_in   (cmd_page),
      .eng_done  (done_v[d]),
      .eng_ack   (ack_v[d]),
      .eng_start (start_v[d]),
      .eng_page  (page_v[d]),
      .idle      (idle_v[d]),
      .flag      (flag_v[d]),
      .flag_ack  (fack_v[d]),
      .ovf       (ovf_v[d])
    );
  end

  assign tx_start = start_v[DIR_TX];
  assign rx_start = start_v[DIR_RX];
  assign tx_page  = page_v[DIR_TX];
  assign rx_page  = page_v[DIR_RX];
  assign tx_ovf   = ovf_v[DIR_TX];
  assign rx_ovf   = ovf_v[DIR_RX];

  always_comb begin
    status              = 8'h00;
    status[ST_TX_FLAG]  = flag_v[DIR_TX];
    status[ST_TX_ACK]   = fack_v[DIR_TX];
    status[ST_RX_FLAG]  = flag_v[DIR_RX];
    status[ST_RX_INH]   = idle_v[DIR_RX];
    status[ST_TX_AVAIL] = idle_v[DIR_TX];
  end

  assign irq = (flag_v[DIR_TX] && irq_en_tx) || (flag_v[DIR_RX] && irq_en_rx);

  assign rx_fack_unused  = fack_v[DIR_RX];
  assign cfg_bits_unused = ^{cfg_data[7], cfg_data[5:0]};
endmodule

// File: rtl/ccq_checker.sv
module ccq_checker
  import ccq_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       chain_q,
  input logic       cmd_wr,
  input logic [1:0] cmd_op,
  input logic       tx_start,
  input logic       rx_start,
  input logic       tx_done,
  input logic [7:0] status,
  input logic       tx_ovf,
  input logic       rx_ovf,
  input logic       irq,
  input logic       irq_en_tx,
  input logic       irq_en_rx
);
  p_tx_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  p_rx_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rx_start |=> !rx_start);

  p_avail_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_op == OP_TX_EN) |=> !status[ST_TX_AVAIL]);

  p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (tx_ovf && !(cmd_wr && cmd_op == OP_TX_CLR)) |=> tx_ovf);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (!chain_q && !rx_ovf) |=> !rx_ovf);

  p_done_flag_r7: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> status[ST_TX_FLAG]);

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (status[ST_TX_FLAG] && !(cmd_wr && cmd_op == OP_TX_CLR)) |=> status[ST_TX_FLAG]);

  p_irq_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (!irq_en_tx && !irq_en_rx) |-> !irq);
endmodule

bind chain_cmd_ctrl ccq_checker u_ccq_checker (
  .clk       (clk),
  .rst       (rst),
  .chain_q   (chain_q),
  .cmd_wr    (cmd_wr),
  .cmd_op    (cmd_op),
  .tx_start  (tx_start),
  .rx_start  (rx_start),
  .tx_done   (tx_done),
  .status    (status),
  .tx_ovf    (tx_ovf),
  .rx_ovf    (rx_ovf),
  .irq       (irq),
  .irq_en_tx (irq_en_tx),
  .irq_en_rx (irq_en_rx)
);

// File: tb/chain_cmd_ctrl_tb.sv
module chain_cmd_ctrl_tb;
  localparam int PW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_wr;
  logic [7:0]    cfg_data;
  logic          cmd_wr;
  logic [1:0]    cmd_op;
  logic [PW-1:0] cmd_page;
  logic          irq_en_tx, irq_en_rx;
  logic          tx_start, rx_start;
  logic [PW-1:0] tx_page, rx_page;
  logic          tx_done, tx_ack, rx_done;
  logic [7:0]    status;
  logic          tx_ovf, rx_ovf, irq;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  chain_cmd_ctrl #(.PAGE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .cmd_wr(cmd_wr), .cmd_op(cmd_op), .cmd_page(cmd_page),
    .irq_en_tx(irq_en_tx), .irq_en_rx(irq_en_rx),
    .tx_start(tx_start), .tx_page(tx_page), .tx_done(tx_done), .tx_ack(tx_ack),
    .rx_start(rx_start), .rx_page(rx_page), .rx_done(rx_done),
    .status(status), .tx_ovf(tx_ovf), .rx_ovf(rx_ovf), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic put(input logic [1:0] op, input logic [PW-1:0] pg);
    cmd_wr = 1'b1; cmd_op = op; cmd_page = pg;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_data = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic txdone(input logic a);
    tx_done = 1'b1; tx_ack = a;
    @(negedge clk);
    tx_done = 1'b0; tx_ack = 1'b0;
  endtask

  task automatic rxdone();
    rx_done = 1'b1;
    @(negedge clk);
    rx_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_wr = 0; cfg_data = 0; cmd_wr = 0; cmd_op = 0; cmd_page = 0;
    irq_en_tx = 1; irq_en_rx = 1; tx_done = 0; tx_ack = 0; rx_done = 0;
    repeat (3) tick();
    rst = 1'b0;
    // R1 reset state
    chk("R1 status", status, 8'h11);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", {tx_ovf, rx_ovf}, 0);
    chk("R1 start", {tx_start, rx_start}, 0);

    // R1/R6 default non-chaining: replacement of waiting command
    put(0, 2);
    put(0, 9);
    chk("R3 start page", {tx_start, tx_page}, {1'b1, 4'd2});
    put(0, 11);
    chk("R6 no ovf", tx_ovf, 0);
    chk("R3 single pulse", tx_start, 0);
    txdone(1);
    chk("R7 flag", status[7], 1);
    tick();
    chk("R6 replaced page", {tx_start, tx_page}, {1'b1, 4'd11});
    txdone(0);
    put(2, 0);
    chk("R8 second head", status[7:6], 2'b10);
    put(2, 0);
    chk("R9 drained", status, 8'h11);

    // R3/R7/R11 page and ack sweep
    for (int p = 0; p < 16; p++) begin
      put(0, PW'(p));
      chk("R3 avail low", status[0], 0);
      tick();
      chk("R3 start", {tx_start, tx_page}, {1'b1, 4'(p)});
      txdone(p[0]);
      chk("R7 flag+ack", status[7:6], {1'b1, p[0]});
      chk("R11 avail live", status[0], 1);
      chk("R10 irq", irq, 1);
      put(2, 0);
      chk("R9 cleared", status, 8'h11);
      chk("R10 irq off", irq, 0);
    end

    // R2 chaining on, R4/R5/R8/R10
    cfg(8'h40);
    put(0, 3);
    put(0, 5);
    chk("R4 first start", {tx_start, tx_page}, {1'b1, 4'd3});
    put(0, 7);
    chk("R5 ovf set", tx_ovf, 1);
    chk("R5 no start", tx_start, 0);
    txdone(1);
    chk("R7 flag ack1", status[7:6], 2'b11);
    tick();
    chk("R4 chained start", {tx_start, tx_page}, {1'b1, 4'd5});
    txdone(0);
    chk("R8 head kept", status[7:6], 2'b11);
    chk("R5 ovf held", tx_ovf, 1);
    put(2, 0);
    chk("R8 second moves up", status[7:6], 2'b10);
    chk("R10 irq kept", irq, 1);
    chk("R5 ovf cleared", tx_ovf, 0);
    put(2, 0);
    chk("R9 empty", status, 8'h11);
    chk("R10 irq low", irq, 0);

    // R10/R12 interleaved directions with mask sweep
    for (int m = 0; m < 4; m++) begin
      irq_en_tx = m[0]; irq_en_rx = m[1];
      put(1, PW'(4 + m));
      chk("R12 rx inhibited low", status[4], 0);
      put(0, 6);
      chk("R12 rx start", {rx_start, rx_page}, {1'b1, 4'(4 + m)});
      tick();
      chk("R12 tx start", {tx_start, tx_page}, {1'b1, 4'd6});
      rxdone();
      chk("R12 rx flag", status[5:4], 2'b11);
      chk("R10 rx irq", irq, m[1]);
      txdone(1);
      chk("R12 both flags", status, 8'hF1);
      chk("R10 both irq", irq, m[0] | m[1]);
      put(3, 0);
      chk("R12 rx cleared", status, 8'hD1);
      chk("R10 tx irq", irq, m[0]);
      put(2, 0);
      chk("R10 none", {status, irq}, {8'h11, 1'b0});
    end
    irq_en_tx = 1; irq_en_rx = 1;

    // R9 clear with nothing queued
    put(2, 0);
    put(3, 0);
    chk("R9 empty clear", status, 8'h11);

    // R5 receive overflow
    put(1, 1);
    put(1, 2);
    put(1, 3);
    chk("R5 rx ovf", rx_ovf, 1);
    chk("R12 tx ovf untouched", tx_ovf, 0);
    rxdone();
    tick();
    chk("R4 rx chained", {rx_start, rx_page}, {1'b1, 4'd2});
    rxdone();
    put(3, 0);
    chk("R5 rx ovf cleared", rx_ovf, 0);
    put(3, 0);
    chk("R9 rx drained", status, 8'h11);

    // R2 chaining off again: no overflow
    cfg(8'h00);
    put(0, 1);
    put(0, 2);
    put(0, 3);
    chk("R2 off no ovf", tx_ovf, 0);
    txdone(0);
    tick();
    chk("R6 last page", {tx_start, tx_page}, {1'b1, 4'd3});
    txdone(1);
    put(2, 0);
    put(2, 0);
    chk("R9 final", {status, irq}, {8'h11, 1'b0});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule